// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns a module clock into the two timing strobes a UART needs. One is a 16x oversampling strobe for the receiver's sampler. The other is a bit-rate strobe for the shifter. The divisor has a 13-bit integer part and a 5-bit fine-adjust part in units of 1/32 of a clock. The average strobe period can therefore land between whole clock counts, and the bit rate is the module clock divided by 16 x (divisor + fine/32).

Configuration arrives as byte writes to three 8-bit registers: a high divisor byte, a low divisor byte and a fine-adjust control byte. A write to the high byte is only held in a staging register. The new integer divisor becomes active when the low byte is written, so a rate change is never half applied. That same low-byte write also restarts the strobe counters and the fractional phase. A fine-adjust write applies at once and does not restart anything.

Each fractional step is made by a 5-bit phase accumulator. Once per sample period it adds the fine value. A period in which that addition carries out of 5 bits is one clock longer.

Top module: `uart_frac_baud_gen`

## Requirements
- R1: After a low-byte write that loads integer divisor D (D > 0) with fine value F, the first 32 sample strobes together span exactly 32·D + F clock cycles, counted from the clock edge that captured the write.
- R2: The active divisor is {high byte bits [4:0], low byte bits [7:0]}, with the high byte bits as the upper five bits of the 13-bit value.
- R3: The fine value is control byte bits [4:0]. Every sample period lasts D or D+1 cycles. With F = 16 the periods after a commit run D, D+1, D, D+1.
- R4: Bits [7:5] of the high divisor byte have no effect on the divisor.
- R5: While the active divisor is zero, neither strobe is ever asserted.
- R6: A high-byte write alone leaves the running rate unchanged. The staged value applies at the next low-byte write.
- R7: A low-byte write clears the period counter, the fractional phase and the strobe counter. The first sample strobe then appears exactly D cycles after the capturing edge.
- R8: The bit-rate strobe is asserted together with every 16th sample strobe after a commit (the 16th, 32nd, ...) and never at any other time.
- R9: Register select encoding is 0 = high divisor byte, 1 = low divisor byte, 2 = fine-adjust control byte. Select value 3 is ignored. Bits [7:5] of the control byte are ignored.
- R10: After reset the active divisor is zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_sel | input | 2 | Register select (0 high, 1 low, 2 fine, 3 none) |
| cfg_wr_data | input | 8 | Configuration byte |
| sample_tick | output | 1 | 16x oversampling strobe, one clock wide |
| bit_tick | output | 1 | Bit-rate strobe, one clock wide, coincident with a sample strobe |

## Verification
A wrong fractional phase cannot be seen in a single period. It appears as a total cycle count over 32 sample strobes that is off by one or more, or as a D/D+1 sequence in the wrong order. The bench therefore measures whole 32-strobe windows and also individual periods straight after a commit. A counter that fails to clear shows up on the very first strobe after the low-byte write, and in the strobe index at which the first bit-rate strobe appears. A bad staging path shows up within one period after the low-byte write, as a period that does not match the expected divisor.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 13;
    localparam int FINE_W   = 5;
    localparam int OVS_RATE = 16;

    typedef enum logic [1:0] {
        SEL_DIV_HI = 2'd0,
        SEL_DIV_LO = 2'd1,
        SEL_FINE   = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    // Join staged upper bits and the low byte into one divisor.
    function automatic logic [DIV_W-1:0] join_div(
        input logic [DIV_W-BYTE_W-1:0] upper,
        input logic [BYTE_W-1:0]       lower
    );
        return {upper, lower};
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import uart_baud_pkg::*;
#(
    parameter int REG_W  = BYTE_W,
    parameter int SBR_W  = DIV_W,
    parameter int FRAC_W = FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [SBR_W-1:0]  div_q,
    output logic [FRAC_W-1:0] fine_q,
    output logic              commit
);
    localparam int UP_W = SBR_W - REG_W;

    cfg_sel_e         sel;
    logic [UP_W-1:0]  upper_stage;

    assign sel    = cfg_sel_e'(wr_sel);
    assign commit = wr_en && (sel == SEL_DIV_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_stage <= '0;
            div_q       <= '0;
            fine_q      <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DIV_HI: upper_stage <= wr_data[UP_W-1:0];
                SEL_DIV_LO: div_q       <= join_div(upper_stage, wr_data);
                SEL_FINE:   fine_q      <= wr_data[FRAC_W-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/baud_frac_phase.sv
module baud_frac_phase #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    input  logic [FRAC_W-1:0] fine,
    output logic              stretch
);
    logic [FRAC_W-1:0] phase_q;
    logic [FRAC_W:0]   sum;

    assign sum     = {1'b0, phase_q} + {1'b0, fine};
    assign stretch = sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase_q <= '0;
        else if (advance)
            phase_q <= sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div #(
    parameter int SBR_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [SBR_W-1:0] div,
    input  logic             stretch,
    output logic             tick
);
    localparam int CNT_W = SBR_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             live;

    assign live = (div != '0);
    assign last = {1'b0, div} + {{(CNT_W-1){1'b0}}, stretch} - {{(CNT_W-1){1'b0}}, 1'b1};
    // Greater-or-equal keeps the period bounded if the fine value shrinks mid-period.
    assign tick = live && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || clear || !live)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/baud_bit_count.sv
module baud_bit_count #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample_tick,
    output logic bit_tick
);
    localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    logic [SUB_W-1:0] sub_q;

    assign bit_tick = sample_tick && (sub_q == SUB_LAST);

    generate
        if ((1 << SUB_W) == OVS) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst || clear)
                    sub_q <= '0;
                else if (sample_tick)
                    sub_q <= sub_q + 1'b1;
            end
        end else begin : g_any
            always_ff @(posedge clk) begin
                if (rst || clear)
                    sub_q <= '0;
                else if (sample_tick)
                    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/uart_frac_baud_gen.sv
module uart_frac_baud_gen
    import uart_baud_pkg::*;
#(
    parameter int REG_W  = BYTE_W,
    parameter int SBR_W  = DIV_W,
    parameter int FRAC_W = FINE_W,
    parameter int OVS    = OVS_RATE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_sel,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic             sample_tick,
    output logic             bit_tick
);
    logic [SBR_W-1:0]  sbr_q;
    logic [FRAC_W-1:0] fine_q;
    logic              commit;
    logic              stretch;

    baud_cfg_regs #(
        .REG_W (REG_W),
        .SBR_W (SBR_W),
        .FRAC_W(FRAC_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr_en),
        .wr_sel (cfg_wr_sel),
        .wr_data(cfg_wr_data),
        .div_q  (sbr_q),
        .fine_q (fine_q),
        .commit (commit)
    );

    baud_frac_phase #(
        .FRAC_W(FRAC_W)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .clear  (commit),
        .advance(sample_tick),
        .fine   (fine_q),
        .stretch(stretch)
    );

    baud_tick_div #(
        .SBR_W(SBR_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .clear  (commit),
        .div    (sbr_q),
        .stretch(stretch),
        .tick   (sample_tick)
    );

    baud_bit_count #(
        .OVS(OVS)
    ) u_bits (
        .clk        (clk),
        .rst        (rst),
        .clear      (commit),
        .sample_tick(sample_tick),
        .bit_tick   (bit_tick)
    );

endmodule

// File: rtl/uart_frac_baud_gen_chk.sv
module uart_frac_baud_gen_chk #(
    parameter int SBR_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [1:0]       cfg_wr_sel,
    input logic [SBR_W-1:0] sbr_q,
    input logic             sample_tick,
    input logic             bit_tick
);
    // R8
    bit_with_sample_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    // R8
    bit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R5
    zero_div_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (sbr_q == '0) |-> (!sample_tick && !bit_tick));

    // R6
    hi_write_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wr_sel == 2'd0) |=> $stable(sbr_q));

    // R9
    unused_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wr_sel == 2'd3) |=> $stable(sbr_q));

    // R3
    min_period_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && sbr_q > 1 && !(cfg_wr_en && cfg_wr_sel == 2'd1)) |=> !sample_tick);

endmodule

bind uart_frac_baud_gen uart_frac_baud_gen_chk #(.SBR_W(SBR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_sel (cfg_wr_sel),
    .sbr_q      (sbr_q),
    .sample_tick(sample_tick),
    .bit_tick   (bit_tick)
);

// File: tb/tb_uart_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_sel = 2'd0;
    logic [7:0] cfg_wr_data = 8'd0;
    logic       sample_tick;
    logic       bit_tick;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_frac_baud_gen dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_sel (cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data),
        .sample_tick(sample_tick),
        .bit_tick   (bit_tick)
    );

    // {high byte, low byte, control byte, expected cycles for 32 sample strobes}
    localparam logic [39:0] VEC [7] = '{
        {8'h00, 8'h01, 8'h00, 16'd32},
        {8'h00, 8'h03, 8'h00, 16'd96},
        {8'h00, 8'h04, 8'h10, 16'd144},
        {8'h00, 8'h05, 8'h1F, 16'd191},
        {8'hE0, 8'h02, 8'h01, 16'd65},
        {8'h01, 8'h02, 8'h07, 16'd8263},
        {8'h00, 8'h07, 8'hE3, 16'd227}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts and ends just after a negative edge.
    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        cfg_wr_en   = 1'b1;
        @(posedge clk);
        #1 cfg_wr_en = 1'b0;
    endtask

    // Counts negative edges until n sample strobes have been seen.
    task automatic measure(input int n, output int cycles, output int bits, output int first_bit);
        int ticks = 0;
        cycles = 0; bits = 0; first_bit = 0;
        while (ticks < n && cycles < 20000) begin
            @(negedge clk);
            cycles++;
            if (sample_tick) begin
                ticks++;
                if (bit_tick) begin
                    bits++;
                    if (first_bit == 0) first_bit = ticks;
                end
            end
        end
    endtask

    task automatic wait_tick();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!sample_tick && guard < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc, bits, fb, seen;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10 / R5: reset state, divisor zero, no strobes.
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        check(seen == 0, "R10 no strobes after reset", seen, 0);

        // Table walk: R1, R2, R3, R4, R8, R9.
        for (int v = 0; v < 7; v++) begin
            wr(2'd0, VEC[v][39:32]);
            wr(2'd2, VEC[v][23:16]);
            wr(2'd1, VEC[v][31:24]);
            measure(32, cyc, bits, fb);
            check(cyc == int'(VEC[v][15:0]), "R1 R2 R4 R9 32-strobe span", cyc, int'(VEC[v][15:0]));
            check(bits == 2, "R8 bit strobes per 32", bits, 2);
            check(fb == 16, "R8 first bit strobe index", fb, 16);
        end

        // R3: D=4, F=16 alternates 4,5,4,5.
        wr(2'd0, 8'h00); wr(2'd2, 8'h10); wr(2'd1, 8'h04);
        for (int k = 0; k < 4; k++) begin
            measure(1, cyc, bits, fb);
            check(cyc == ((k % 2) ? 5 : 4), "R3 period sequence", cyc, (k % 2) ? 5 : 4);
        end

        // R6: high-byte write alone keeps the rate.
        wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h03);
        wr(2'd0, 8'h01);
        wait_tick();
        measure(32, cyc, bits, fb);
        check(cyc == 96, "R6 rate held after high write", cyc, 96);
        wr(2'd1, 8'h03);
        measure(1, cyc, bits, fb);
        check(cyc == 259, "R6 R2 staged high applies on low write", cyc, 259);

        // R9: select 3 ignored.
        wr(2'd0, 8'h00); wr(2'd1, 8'h03);
        wr(2'd3, 8'h55);
        wait_tick();
        measure(8, cyc, bits, fb);
        check(cyc == 24, "R9 select 3 ignored", cyc, 24);

        // R7: commit mid-period restarts counters.
        wr(2'd1, 8'h05);
        repeat (2) @(negedge clk);
        #1;
        wr(2'd1, 8'h05);
        measure(1, cyc, bits, fb);
        check(cyc == 5, "R7 first strobe after commit", cyc, 5);
        wr(2'd2, 8'h09); wr(2'd1, 8'h06);
        measure(32, cyc, bits, fb);
        check(cyc == 201, "R7 phase cleared by commit", cyc, 201);
        check(fb == 16, "R7 R8 bit counter cleared", fb, 16);

        // R5: divisor zero silences both strobes.
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        check(seen == 0, "R5 zero divisor silent", seen, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule